// File: doc/BRIEF.md
# Receive byte queue with programmable threshold

This block stores bytes arriving from a serial bus byte engine until a host reads them through a data register. It holds up to 16 bytes in arrival order. The host programs a zero-based threshold: writing N asks for notice once N+1 bytes are waiting. The block drives a level that the interrupt logic can latch. It also reports a zero-based fill level, plus empty and full flags.

The threshold can be lowered in the middle of a transfer. The last, shorter chunk of a message then still raises the level. When the queue is full, the block drops its ready output toward the engine, which then holds the bus clock low. A received byte is never overwritten. A synchronous soft reset flushes the queue and returns the threshold to zero.

Top module: `rx_watermark_fifo`

## Requirements
- R1: After reset, `is_empty`=1, `is_full`=0, `fill_level`=0, `thresh_hit`=0, `push_ready`=1 and the threshold is 0.
- R2: Bytes are returned on `rd_data` in the order they were accepted. `rd_data` shows the oldest stored byte combinationally, and a cycle with `rd_pop` high removes that byte at the clock edge.
- R3: While 16 bytes are stored, `push_ready` is 0. A `push_valid` in that state is ignored, and the stored bytes and count are unchanged.
- R4: `fill_level` equals the stored count minus one when the queue is not empty, and 0 when it is empty. `is_empty` is 1 exactly when the count is 0.
- R5: `is_full` is 1 exactly when the count is 16.
- R6: `thresh_hit` is 1 exactly when the stored count is at least the threshold plus one. It is re-evaluated after every push, pop and threshold write.
- R7: A threshold write (`thr_wr`, value `thr_data`) takes effect at the next clock edge, including while bytes are stored.
- R8: A `rd_pop` while the queue is empty gives `rd_data`=0 and changes no state.
- R9: `soft_rst` empties the queue and sets the threshold to 0 at the next edge. It overrides any push, pop or threshold write in the same cycle.
- R10: A push and a pop in the same cycle, with the queue neither empty nor full, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush and threshold default |
| push_valid | input | 1 | Engine offers a byte |
| push_data | input | 8 | Byte from the engine |
| push_ready | output | 1 | Queue can accept a byte |
| rd_pop | input | 1 | Host reads the data register |
| rd_data | output | 8 | Oldest stored byte, or 0 when empty |
| thr_wr | input | 1 | Threshold write strobe |
| thr_data | input | 4 | Zero-based threshold value |
| fill_level | output | 4 | Stored count minus one, or 0 when empty |
| is_empty | output | 1 | No bytes stored |
| is_full | output | 1 | 16 bytes stored |
| thresh_hit | output | 1 | Count is at least threshold plus one |

## Verification
For every threshold value 0 to 15, the queue is filled from empty to full and then drained. This checks the threshold level at each count in both directions, and it separates an off-by-one in the comparison from a wrong register value. Distinct byte patterns show whether ordering and pointer wrap are correct. A threshold lowered after partial filling checks that a mid-transfer write takes effect. Pushes into a full queue, pops from an empty one, combined push and pop, and a soft reset that collides with other strobes check each override rule.

// File: rtl/rx_watermark_fifo.sv
module rx_watermark_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             rd_pop,
  output logic [WIDTH-1:0] rd_data,
  input  logic             thr_wr,
  input  logic [AW-1:0]    thr_data,
  output logic [AW-1:0]    fill_level,
  output logic             is_empty,
  output logic             is_full,
  output logic             thresh_hit
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, thr_q;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign is_empty   = (count == '0);
  assign is_full    = (count == CW'(DEPTH));
  assign push_ready = !is_full;
  assign do_push    = push_valid && push_ready && !soft_rst;
  assign do_pop     = rd_pop && !is_empty && !soft_rst;
  assign rd_data    = is_empty ? '0 : mem[rd_ptr];
  assign fill_level = is_empty ? '0 : AW'(count - 1'b1);
  assign thresh_hit = (count > {1'b0, thr_q});

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      thr_q  <= '0;
    end else if (soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      thr_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (thr_wr) thr_q <= thr_data;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push_valid && !rd_pop && !soft_rst) |=> (is_full && $stable(fill_level)));

  p_empty_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> (fill_level == '0 && !thresh_hit && push_ready));

  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_pop && !push_valid && !soft_rst) |=> is_empty);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (is_empty && !thresh_hit && !is_full));

  p_thr_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !soft_rst && !push_valid && !rd_pop)
      |=> (thresh_hit == ($past(count) > {1'b0, $past(thr_data)})));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && rd_pop && !is_empty && !is_full && !soft_rst) |=> $stable(fill_level));

endmodule

// File: tb/sim_rx_watermark_fifo.sv
module sim_rx_watermark_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, push_valid = 1'b0, rd_pop = 1'b0, thr_wr = 1'b0;
  logic [7:0] push_data = '0;
  logic [3:0] thr_data = '0;
  logic       push_ready, is_empty, is_full, thresh_hit;
  logic [7:0] rd_data;
  logic [3:0] fill_level;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mq[$];
  int thr_m = 0;

  always #10 clk = ~clk;

  rx_watermark_fifo u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .rd_pop(rd_pop), .rd_data(rd_data), .thr_wr(thr_wr), .thr_data(thr_data),
    .fill_level(fill_level), .is_empty(is_empty), .is_full(is_full),
    .thresh_hit(thresh_hit));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int c;
    c = mq.size();
    chk({tag, " R4 empty"}, is_empty, c == 0);
    chk({tag, " R4 fill_level"}, fill_level, (c == 0) ? 0 : c - 1);
    chk({tag, " R5 full"}, is_full, c == 16);
    chk({tag, " R3 ready"}, push_ready, c != 16);
    chk({tag, " R6 thresh_hit"}, thresh_hit, c >= thr_m + 1);
    chk({tag, " R2/R8 rd_data"}, rd_data, (c == 0) ? 0 : mq[0]);
  endtask

  task automatic step(input string tag, input logic pv, input logic [7:0] pd,
                      input logic pp, input logic dw, input logic [3:0] dd,
                      input logic sr);
    logic pop_ok, push_ok;
    push_valid = pv; push_data = pd; rd_pop = pp; thr_wr = dw; thr_data = dd;
    soft_rst = sr;
    #1;
    if (pp) chk({tag, " R2 rd_data at pop"}, rd_data, (mq.size() == 0) ? 0 : mq[0]);
    @(posedge clk);
    if (sr) begin
      mq.delete(); thr_m = 0;
    end else begin
      pop_ok  = pp && mq.size() > 0;
      push_ok = pv && mq.size() < 16;
      if (pop_ok) void'(mq.pop_front());
      if (push_ok) mq.push_back(pd);
      if (dw) thr_m = dd;
    end
    @(negedge clk);
    push_valid = 0; rd_pop = 0; thr_wr = 0; soft_rst = 0;
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    // R1: default threshold 0 -> one byte raises the level
    step("R1 default thr", 1, 8'hA5, 0, 0, 0, 0);
    step("R2 drain", 0, 0, 1, 0, 0, 0);

    // R6 sweep over every threshold, fill then drain
    for (int t = 0; t < 16; t++) begin
      step("R9 flush", 0, 0, 0, 0, 0, 1);
      step("R7 thr write", 0, 0, 0, 1, 4'(t), 0);
      for (int k = 0; k < 16; k++)
        step("R6 fill", 1, 8'((t * 37 + k * 11) ^ 8'h5C), 0, 0, 0, 0);
      step("R3 push full", 1, 8'hFF, 0, 0, 0, 0);
      for (int k = 0; k < 16; k++)
        step("R6 drain", 0, 0, 1, 0, 0, 0);
    end

    // R8: pop on empty
    step("R8 pop empty", 0, 0, 1, 0, 0, 0);
    step("R8 pop empty again", 0, 0, 1, 0, 0, 0);

    // R7: mid-transfer threshold lowering
    step("R7 thr 15", 0, 0, 0, 1, 4'd15, 0);
    for (int k = 0; k < 5; k++) step("R7 partial", 1, 8'(k + 100), 0, 0, 0, 0);
    step("R7 lower thr", 0, 0, 0, 1, 4'd4, 0);
    step("R7 raise thr", 0, 0, 0, 1, 4'd9, 0);
    step("R7 write with push", 1, 8'h77, 0, 1, 4'd5, 0);

    // R10: simultaneous push and pop, pointers wrap
    for (int k = 0; k < 40; k++) step("R10 push+pop", 1, 8'(k * 7 + 3), 1, 0, 0, 0);

    // R3: full then pop while push is offered
    for (int k = 0; k < 12; k++) step("R3 top up", 1, 8'(k + 200), 0, 0, 0, 0);
    step("R3 push+pop full", 1, 8'hEE, 1, 0, 0, 0);
    step("R3 refill", 1, 8'hDD, 0, 0, 0, 0);

    // R9: soft reset overrides all strobes
    step("R9 collide", 1, 8'h11, 1, 1, 4'd7, 1);
    step("R9 thr default", 1, 8'h22, 0, 0, 0, 0);
    step("R2 last", 0, 0, 1, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule